// File: doc/BRIEF.md
# Precision Time Counter with Step and Rate Trim

This block keeps the local time for a precision time protocol node as a 48-bit seconds field and a 30-bit nanoseconds field. While it runs, the nanoseconds field advances once per reference clock cycle by a nominal 8 ns, which matches a 125 MHz reference. When the field reaches one billion it wraps and carries into the seconds field. The live time is driven straight out so that timestamp capture logic next to the block can sample it.

Software reaches the counter through a flat bank of 16-bit words, each selected by a 4-bit address. Through these words it can stage and load an absolute time and freeze a coherent copy of the running time for readback. It can also apply a one-shot step to the seconds field, which adds or subtracts. A one-shot step to the nanoseconds field always adds. Finally, it can program a signed fractional rate trim that lengthens or shortens single ticks by one nanosecond.

Commands are written as bits to a command word. They clear themselves and act in the clock cycle after the write. The register map is:

| Address | Name | Content |
|---|---|---|
| 0 | command | on write: bit0 start, bit1 stop, bit2 load, bit3 snapshot, bit4 seconds step, bit5 nanosecond step. On read: bit0 = running |
| 1, 2, 3 | staged seconds | bits 15:0, 31:16 and 47:32 |
| 4, 5 | staged nanoseconds | bits 15:0, then bits 29:16 in word bits 13:0 |
| 6, 7 | step value | magnitude bits 15:0. Word 7 holds magnitude bits 29:16 in bits 13:0 and the direction in bit 15 (1 = add) |
| 8, 9 | rate trim | magnitude bits 15:0. Word 9 holds magnitude bits 29:16 in bits 13:0 and the direction in bit 15 (1 = faster) |
| 10, 11, 12 | snapshot seconds | bits 15:0, 31:16 and 47:32, read only |
| 13, 14 | snapshot nanoseconds | bits 15:0 and 29:16, read only |

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the counter is stopped. The live seconds and nanoseconds are zero, the command word reads 0 and the snapshot words read 0.
- R2: Writing command bit0 starts the counter and command bit1 stops it; bit1 wins when both are set. When the counter runs with a zero rate trim, the total time grows by exactly 8 ns per clock cycle. When it is stopped and no command is pending, the time holds. Command word bit0 reads back the running state.
- R3: When the nanoseconds field reaches 1,000,000,000 it wraps to the remainder and the seconds field grows by one. The nanoseconds field never leaves the range below one billion after a valid load.
- R4: Command bit2 copies the staged seconds (addresses 1 to 3) and the staged nanoseconds (addresses 4 and 5) into the counter. The copy happens in the cycle after the write. If a step bit is set in the same write, the load takes priority and the step is dropped.
- R5: Command bit3 copies the counter value, as it stands in the cycle after the write, into the snapshot words (addresses 10 to 14). These words keep that value while the counter moves on.
- R6: Command bit4 adds the 30-bit step magnitude to the seconds field when bit 15 of address 7 is 1, and subtracts it when that bit is 0. Subtraction wraps modulo 2^48. The nanoseconds field is left as it was.
- R7: Command bit5 adds the step magnitude (software keeps it below one billion) to the nanoseconds field in place of that cycle's tick, whatever the direction bit says. A sum that reaches one billion wraps and carries one into the seconds field.
- R8: Each running cycle adds the 30-bit rate magnitude into a 32-bit accumulator. On each carry out of that accumulator, the tick is 9 ns when bit 15 of address 9 is 1 and 7 ns when it is 0. Over N cycles the time therefore gains 8N ns plus or minus either floor(N*mag/2^32) or one more.
- R9: Command bits clear themselves. One write produces exactly one action, and later cycles do not repeat it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_addr | input | 4 | Word address for both write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed word (combinational) |
| time_sec | output | 48 | Live seconds |
| time_ns | output | 30 | Live nanoseconds |

## Verification
Seconds steps are swept over every magnitude from 0 to 15 in both directions, plus one large magnitude whose subtraction wraps below zero. This separates a wrong sign, a wrong field and wrong modulo arithmetic. Nanosecond steps are tried just below, exactly at and above the one-billion boundary, with the direction bit both set and clear. These cases show whether the carry works and whether the nanosecond step ignores the direction bit. The rate trim is swept over several magnitudes in both directions and the elapsed time is compared to an arithmetic bound. That comparison catches a wrong accumulator width, a swapped direction and a trim applied while it should be idle. Load against step priority, the coherence of snapshots while the counter runs, and the single effect of a command write each get their own stimulus.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 4;
  localparam int SEC_W   = 48;
  localparam int NS_W    = 30;
  localparam int FRAC_W  = 32;
  localparam int INC_W   = 4;
  localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

  localparam logic [ADDR_W-1:0] A_CMD    = 4'd0;
  localparam logic [ADDR_W-1:0] A_SSEC0  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SSEC1  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SSEC2  = 4'd3;
  localparam logic [ADDR_W-1:0] A_SNS0   = 4'd4;
  localparam logic [ADDR_W-1:0] A_SNS1   = 4'd5;
  localparam logic [ADDR_W-1:0] A_STEP0  = 4'd6;
  localparam logic [ADDR_W-1:0] A_STEP1  = 4'd7;
  localparam logic [ADDR_W-1:0] A_RATE0  = 4'd8;
  localparam logic [ADDR_W-1:0] A_RATE1  = 4'd9;
  localparam logic [ADDR_W-1:0] A_QSEC0  = 4'd10;
  localparam logic [ADDR_W-1:0] A_QSEC1  = 4'd11;
  localparam logic [ADDR_W-1:0] A_QSEC2  = 4'd12;
  localparam logic [ADDR_W-1:0] A_QNS0   = 4'd13;
  localparam logic [ADDR_W-1:0] A_QNS1   = 4'd14;

  // command word, bit0 = start ... bit5 = nanosecond step
  typedef struct packed {
    logic step_ns;
    logic step_sec;
    logic snap;
    logic load;
    logic stop;
    logic start;
  } cmd_t;
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
#(
  parameter int SEC_WIDTH = SEC_W,
  parameter int NS_WIDTH  = NS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [REG_W-1:0]      wdata,
  input  logic [SEC_WIDTH-1:0]  live_sec,
  input  logic [NS_WIDTH-1:0]   live_ns,
  input  logic                  running,
  output logic [REG_W-1:0]      rdata,
  output cmd_t                  cmd,
  output logic [SEC_WIDTH-1:0]  stage_sec,
  output logic [NS_WIDTH-1:0]   stage_ns,
  output logic [NS_WIDTH-1:0]   step_mag,
  output logic                  step_add,
  output logic [NS_WIDTH-1:0]   rate_mag,
  output logic                  rate_fast
);
  localparam int HI_W   = NS_WIDTH - REG_W;
  localparam int CMD_W  = $bits(cmd_t);

  cmd_t                 cmd_q, cmd_d;
  logic [SEC_WIDTH-1:0] ssec_q, ssec_d;
  logic [NS_WIDTH-1:0]  sns_q, sns_d;
  logic [NS_WIDTH-1:0]  step_q, step_d;
  logic                 sdir_q, sdir_d;
  logic [NS_WIDTH-1:0]  rate_q, rate_d;
  logic                 rdir_q, rdir_d;
  logic [SEC_WIDTH-1:0] qsec_q, qsec_d;
  logic [NS_WIDTH-1:0]  qns_q, qns_d;

  always_comb begin
    cmd_d  = '0;
    ssec_d = ssec_q;
    sns_d  = sns_q;
    step_d = step_q;
    sdir_d = sdir_q;
    rate_d = rate_q;
    rdir_d = rdir_q;
    qsec_d = qsec_q;
    qns_d  = qns_q;
    if (cmd_q.snap) begin
      qsec_d = live_sec;
      qns_d  = live_ns;
    end
    if (wr) begin
      unique case (addr)
        A_CMD:   cmd_d = cmd_t'(wdata[CMD_W-1:0]);
        A_SSEC0: ssec_d[15:0]  = wdata;
        A_SSEC1: ssec_d[31:16] = wdata;
        A_SSEC2: ssec_d[47:32] = wdata;
        A_SNS0:  sns_d[15:0]   = wdata;
        A_SNS1:  sns_d[NS_WIDTH-1:16] = wdata[HI_W-1:0];
        A_STEP0: step_d[15:0]  = wdata;
        A_STEP1: begin
          step_d[NS_WIDTH-1:16] = wdata[HI_W-1:0];
          sdir_d = wdata[15];
        end
        A_RATE0: rate_d[15:0]  = wdata;
        A_RATE1: begin
          rate_d[NS_WIDTH-1:16] = wdata[HI_W-1:0];
          rdir_d = wdata[15];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      ssec_q <= '0;
      sns_q  <= '0;
      step_q <= '0;
      sdir_q <= 1'b0;
      rate_q <= '0;
      rdir_q <= 1'b0;
      qsec_q <= '0;
      qns_q  <= '0;
    end else begin
      cmd_q  <= cmd_d;
      ssec_q <= ssec_d;
      sns_q  <= sns_d;
      step_q <= step_d;
      sdir_q <= sdir_d;
      rate_q <= rate_d;
      rdir_q <= rdir_d;
      qsec_q <= qsec_d;
      qns_q  <= qns_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CMD:   rdata = {{(REG_W-1){1'b0}}, running};
      A_SSEC0: rdata = ssec_q[15:0];
      A_SSEC1: rdata = ssec_q[31:16];
      A_SSEC2: rdata = ssec_q[47:32];
      A_SNS0:  rdata = sns_q[15:0];
      A_SNS1:  rdata = {{(REG_W-HI_W){1'b0}}, sns_q[NS_WIDTH-1:16]};
      A_STEP0: rdata = step_q[15:0];
      A_STEP1: rdata = {sdir_q, 1'b0, step_q[NS_WIDTH-1:16]};
      A_RATE0: rdata = rate_q[15:0];
      A_RATE1: rdata = {rdir_q, 1'b0, rate_q[NS_WIDTH-1:16]};
      A_QSEC0: rdata = qsec_q[15:0];
      A_QSEC1: rdata = qsec_q[31:16];
      A_QSEC2: rdata = qsec_q[47:32];
      A_QNS0:  rdata = qns_q[15:0];
      A_QNS1:  rdata = {{(REG_W-HI_W){1'b0}}, qns_q[NS_WIDTH-1:16]};
      default: rdata = '0;
    endcase
  end

  assign cmd       = cmd_q;
  assign stage_sec = ssec_q;
  assign stage_ns  = sns_q;
  assign step_mag  = step_q;
  assign step_add  = sdir_q;
  assign rate_mag  = rate_q;
  assign rate_fast = rdir_q;

  // R5: snapshot holds the live time present at the acting edge
  a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.snap |=> (qsec_q == $past(live_sec)) && (qns_q == $past(live_ns)));

  // R9: a pending command lasts one cycle unless rewritten
  a_r9_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q != '0) && !(wr && addr == A_CMD)) |=> (cmd_q == '0));
endmodule

// File: rtl/ptp_tc_rate.sv
module ptp_tc_rate
  import ptp_tc_pkg::*;
#(
  parameter int MAG_WIDTH = NS_W,
  parameter int ACC_WIDTH = FRAC_W,
  parameter int NOM_INC   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 running,
  input  logic [MAG_WIDTH-1:0] rate_mag,
  input  logic                 rate_fast,
  output logic [INC_W-1:0]     inc
);
  localparam logic [INC_W-1:0] INC_NOM  = INC_W'(NOM_INC);
  localparam logic [INC_W-1:0] INC_FAST = INC_W'(NOM_INC + 1);
  localparam logic [INC_W-1:0] INC_SLOW = INC_W'(NOM_INC - 1);

  logic [ACC_WIDTH-1:0] acc_q, acc_d;
  logic [ACC_WIDTH:0]   sum;
  logic                 carry;

  always_comb begin
    sum   = {1'b0, acc_q} + (ACC_WIDTH+1)'(rate_mag);
    carry = running & sum[ACC_WIDTH];
    acc_d = running ? sum[ACC_WIDTH-1:0] : acc_q;
    if (carry) inc = rate_fast ? INC_FAST : INC_SLOW;
    else       inc = INC_NOM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R8: per-tick increment stays within one nanosecond of nominal
  a_r8_inc_range: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == INC_NOM) || (inc == INC_FAST) || (inc == INC_SLOW));

  // R8: a zero trim never alters the tick
  a_r8_zero_trim: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_mag == '0) |-> (inc == INC_NOM));
endmodule

// File: rtl/ptp_tc_core.sv
module ptp_tc_core
  import ptp_tc_pkg::*;
#(
  parameter int SEC_WIDTH = SEC_W,
  parameter int NS_WIDTH  = NS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_t                 cmd,
  input  logic [SEC_WIDTH-1:0] stage_sec,
  input  logic [NS_WIDTH-1:0]  stage_ns,
  input  logic [NS_WIDTH-1:0]  step_mag,
  input  logic                 step_add,
  input  logic [INC_W-1:0]     inc,
  output logic [SEC_WIDTH-1:0] sec,
  output logic [NS_WIDTH-1:0]  ns,
  output logic                 running
);
  localparam int SUM_W = NS_WIDTH + 1;

  logic [SEC_WIDTH-1:0] sec_q, sec_d, mag_ext, sec_adj;
  logic [NS_WIDTH-1:0]  ns_q, ns_d;
  logic                 run_q, run_d;
  logic [SUM_W-1:0]     ns_sum;
  logic                 wrap;

  always_comb begin
    run_d = run_q;
    if (cmd.start) run_d = 1'b1;
    if (cmd.stop)  run_d = 1'b0;

    if (cmd.step_ns)
      ns_sum = {1'b0, ns_q} + {1'b0, step_mag};
    else if (run_q)
      ns_sum = {1'b0, ns_q} + SUM_W'(inc);
    else
      ns_sum = {1'b0, ns_q};
    wrap = ns_sum >= {1'b0, NS_PER_SEC};

    mag_ext = SEC_WIDTH'(step_mag);
    if (cmd.step_sec) sec_adj = step_add ? mag_ext : (~mag_ext + 1'b1);
    else              sec_adj = '0;

    if (cmd.load) begin
      sec_d = stage_sec;
      ns_d  = stage_ns;
    end else begin
      sec_d = sec_q + SEC_WIDTH'(wrap) + sec_adj;
      ns_d  = wrap ? NS_WIDTH'(ns_sum - {1'b0, NS_PER_SEC}) : ns_sum[NS_WIDTH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
      run_q <= 1'b0;
    end else begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
      run_q <= run_d;
    end
  end

  assign sec     = sec_q;
  assign ns      = ns_q;
  assign running = run_q;

  // R4: load copies the staged time
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.load |=> (sec_q == $past(stage_sec)) && (ns_q == $past(stage_ns)));

  // R2: idle and stopped means the time holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && cmd == '0) |=> ($stable(sec_q) && $stable(ns_q)));

  // R2: stop command leaves the counter stopped
  a_r2_stop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.stop |=> !run_q);

  // R3: nanoseconds stay below one billion
  a_r3_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.load && ns_q < NS_PER_SEC && step_mag < NS_PER_SEC) |=> (ns_q < NS_PER_SEC));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int NOM_INC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [SEC_W-1:0]  time_sec,
  output logic [NS_W-1:0]   time_ns
);
  cmd_t             cmd;
  logic [SEC_W-1:0] stage_sec;
  logic [NS_W-1:0]  stage_ns, step_mag, rate_mag;
  logic             step_add, rate_fast, running;
  logic [INC_W-1:0] inc;

  ptp_tc_regs #(.SEC_WIDTH(SEC_W), .NS_WIDTH(NS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .live_sec(time_sec), .live_ns(time_ns), .running(running), .rdata(reg_rdata),
    .cmd(cmd), .stage_sec(stage_sec), .stage_ns(stage_ns), .step_mag(step_mag),
    .step_add(step_add), .rate_mag(rate_mag), .rate_fast(rate_fast)
  );

  ptp_tc_rate #(.MAG_WIDTH(NS_W), .ACC_WIDTH(FRAC_W), .NOM_INC(NOM_INC)) u_rate (
    .clk(clk), .rst_n(rst_n), .running(running), .rate_mag(rate_mag),
    .rate_fast(rate_fast), .inc(inc)
  );

  ptp_tc_core #(.SEC_WIDTH(SEC_W), .NS_WIDTH(NS_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .stage_sec(stage_sec), .stage_ns(stage_ns),
    .step_mag(step_mag), .step_add(step_add), .inc(inc), .sec(time_sec),
    .ns(time_ns), .running(running)
  );
endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  localparam int CLK_PERIOD = 8;
  localparam longint BIL = 64'd1_000_000_000;

  logic        clk, rst_n, reg_wr;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [47:0] time_sec;
  logic [29:0] time_ns;

  int n_chk, n_fail;
  bit done;

  ptp_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_sec(time_sec), .time_ns(time_ns)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // issue a command and wait until it has acted
  task automatic cmd(input logic [15:0] bits);
    wr(4'd0, bits);
    @(negedge clk);
  endtask

  task automatic stage(input longint s, input longint n);
    wr(4'd1, 16'(s)); wr(4'd2, 16'(s >> 16)); wr(4'd3, 16'(s >> 32));
    wr(4'd4, 16'(n)); wr(4'd5, 16'(n >> 16));
  endtask

  function automatic longint total();
    return longint'(time_sec) * BIL + longint'(time_ns);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finish_run();
  end

  initial begin
    logic [15:0] d, d1, d2;
    longint t0, t1, prev, ls, ln, qs, qn, c, lo, hi;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(time_sec == 0, "R1 sec", time_sec, 0);
    check(time_ns == 0, "R1 ns", time_ns, 0);
    rd(4'd0, d); check(d == 0, "R1 cmd word", d, 0);
    rd(4'd10, d); check(d == 0, "R1 snapshot", d, 0);

    // R2 run at nominal rate, then stop and hold
    cmd(16'h0001);
    rd(4'd0, d); check(d == 1, "R2 running flag", d, 1);
    t0 = total(); repeat (20) @(negedge clk); t1 = total();
    check(t1 - t0 == 160, "R2 nominal advance", t1 - t0, 160);
    cmd(16'h0003);
    rd(4'd0, d); check(d == 0, "R2 stop wins", d, 0);
    t0 = total(); repeat (10) @(negedge clk); t1 = total();
    check(t1 == t0, "R2 hold when stopped", t1, t0);

    // R3 rollover
    stage(5, BIL - 24); cmd(16'h0004);
    cmd(16'h0001);
    prev = total();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(total() - prev == 8, "R3 step across wrap", total() - prev, 8);
      check(time_ns < BIL, "R3 ns range", time_ns, BIL - 1);
      prev = total();
    end
    check(time_sec == 6, "R3 carry into seconds", time_sec, 6);
    cmd(16'h0002);

    // R6 seconds step sweep
    for (int m = 0; m < 16; m++) begin
      for (int dir = 0; dir < 2; dir++) begin
        stage(1000, 500); cmd(16'h0004);
        wr(4'd6, 16'(m)); wr(4'd7, dir ? 16'h8000 : 16'h0000);
        cmd(16'h0010);
        check(time_sec == (dir ? 1000 + m : 1000 - m), "R6 seconds step",
              time_sec, dir ? 1000 + m : 1000 - m);
        check(time_ns == 500, "R6 ns untouched", time_ns, 500);
      end
    end
    // R6 large subtraction wraps modulo 2^48
    stage(10, 7); cmd(16'h0004);
    wr(4'd6, 16'hCDEF); wr(4'd7, 16'h02AB);
    cmd(16'h0010);
    t0 = (longint'(10) - longint'(32'h02ABCDEF)) & 64'hFFFF_FFFF_FFFF;
    check(longint'(time_sec) == t0, "R6 wrap below zero", time_sec, t0);

    // R9 command acted once only
    repeat (5) @(negedge clk);
    check(longint'(time_sec) == t0, "R9 no repeat of step", time_sec, t0);

    // R7 nanosecond step cases
    begin
      longint n0 [6] = '{0, 100, 999_999_999, 500_000_000, 123, 999_999_000};
      longint mg [6] = '{1, 999_999_900, 1, 499_999_999, 0, 999_999_999};
      for (int k = 0; k < 6; k++) begin
        stage(40, n0[k]); cmd(16'h0004);
        wr(4'd6, 16'(mg[k])); wr(4'd7, ((k % 2) ? 16'h8000 : 16'h0000) | 16'(mg[k] >> 16));
        cmd(16'h0020);
        qs = 40 + (n0[k] + mg[k]) / BIL;
        qn = (n0[k] + mg[k]) % BIL;
        check(time_ns == qn, "R7 ns after step", time_ns, qn);
        check(time_sec == qs, "R7 carry", time_sec, qs);
      end
    end

    // R4 load wins over steps in the same write
    stage(77, 88);
    wr(4'd6, 16'd5); wr(4'd7, 16'h8000);
    cmd(16'h0034);
    check(time_sec == 77, "R4 load priority sec", time_sec, 77);
    check(time_ns == 88, "R4 load priority ns", time_ns, 88);

    // R5 snapshot while running
    cmd(16'h0001);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 16'h0008;
    @(negedge clk);
    reg_wr = 1'b0;
    ls = time_sec; ln = time_ns;
    repeat (6) @(negedge clk);
    rd(4'd10, d); rd(4'd11, d1); rd(4'd12, d2);
    qs = {d2, d1, d};
    rd(4'd13, d); rd(4'd14, d1);
    qn = {d1, d};
    check(qs == ls, "R5 snapshot sec", qs, ls);
    check(qn == ln, "R5 snapshot ns", qn, ln);
    check(total() != ls * BIL + ln, "R5 live moved on", total(), ls * BIL + ln);

    // R8 rate trim sweep
    begin
      longint mags [4] = '{536_870_912, 1_000_000, 805_306_368, 1_073_741_823};
      for (int k = 0; k < 4; k++) begin
        for (int f = 0; f < 2; f++) begin
          wr(4'd8, 16'(mags[k]));
          wr(4'd9, (f ? 16'h8000 : 16'h0000) | 16'(mags[k] >> 16));
          @(negedge clk);
          t0 = total(); repeat (1000) @(negedge clk); t1 = total();
          c = (longint'(1000) * mags[k]) >> 32;
          lo = f ? 8000 + c : 8000 - c - 1;
          hi = f ? 8000 + c + 1 : 8000 - c;
          check((t1 - t0 >= lo) && (t1 - t0 <= hi), "R8 trimmed advance", t1 - t0,
                f ? 8000 + c : 8000 - c);
        end
      end
      wr(4'd8, 16'd0); wr(4'd9, 16'd0);
      @(negedge clk);
      t0 = total(); repeat (500) @(negedge clk); t1 = total();
      check(t1 - t0 == 4000, "R8 zero trim", t1 - t0, 4000);
    end

    finish_run();
  end
endmodule